// File: doc/BRIEF.md
# Dual-Channel Output Compare Pulse/PWM Generator

This block holds two pulse generators, each with its own up-counter and two compare values: a set point and a clear point. A channel can run freely, be cleared by a chosen sync line, or wait for a chosen trigger line before it counts. In continuous mode a channel makes a PWM wave. In single-pulse mode it makes one pulse and then stops until its control word is written again.

Both channels can be joined into one counter of twice the width. Channel 0 then holds the low half and channel 1 the high half, and channel 0's control word governs the joined unit. Software programs everything through a narrow register write port. A shared clock enable paces the counters.

Top module: `ocpwm_pair`

## Requirements
- R1: With sync select 0, an enabled channel's counter starts at 0 after enable and adds one on each cycle where `clk_en` is high. It wraps from all-ones to zero. It holds on cycles where `clk_en` is low.
- R2: On a counting cycle, a counter value equal to the clear point drives the output low on the next cycle. Otherwise, a value equal to the set point drives it high. When the two points are equal, the output stays low.
- R3: Control word layout: bit 0 enable, bit 1 single-pulse, bit 2 trigger-mode, bit 3 join, bits 8:4 sync select. A select code k (1..31) picks `sync_in[k-1]`. Pulses on lines that are not selected have no effect.
- R4: With a nonzero select and trigger-mode 0, a pulse on the selected line clears the counter on the next edge. This clear wins over counting.
- R5: With a nonzero select and trigger-mode 1, the counter holds until a pulse arrives on the selected line. It counts from the cycle after that pulse onward. Later pulses have no effect.
- R6: In single-pulse mode, a clear-point match stops the counter and holds the output low. Any write to that channel's control word re-arms the channel.
- R7: Reset clears every register. A channel whose enable is 0 holds its counter at 0 and its output low, and it forgets a seen trigger.
- R8: The channels are joined only when the join bit is set in both control words. In joined mode, a counting cycle on which the low counter wraps adds one to the high counter. Both compares use the full-width value, with channel 1 supplying the high halves. Both output pins show the joined output.
- R9: Register addresses are 0 control, 1 set point and 2 clear point, with `wr_chan` picking the channel. A compare write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Count enable shared by both channels |
| sync_in | input | 2**SW-1 | Sync/trigger event lines |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 1 | Channel picked for the write |
| wr_addr | input | 2 | Register address |
| wr_data | input | CW | Write data |
| pwm_out | output | 2 | Channel output pins |

## Verification
The bench builds the block with a 9-bit counter (CW=9) and 5-bit select (SW=5). This is the smallest width that still holds the control fields. With it, a single channel wraps in 512 counting cycles. A joined compare whose high half is 1 or 2 is then reached within about a thousand cycles, and so is the carry into the high counter. Gaps in the clock enable, sync pulses on selected and unselected lines, and re-arming all fit in a short run.

// File: rtl/ocpwm_pair.sv
module ocpwm_pair #(
  parameter int CW = 16,
  parameter int SW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en,
  input  logic [(1<<SW)-2:0]   sync_in,
  input  logic                 wr_en,
  input  logic                 wr_chan,
  input  logic [1:0]           wr_addr,
  input  logic [CW-1:0]        wr_data,
  output logic [1:0]           pwm_out
);
  localparam int SELLO = 4;
  localparam int SELHI = SELLO + SW - 1;
  localparam int NSRC  = (1 << SW) - 1;
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] ctl [2];
  logic [CW-1:0] pri [2];
  logic [CW-1:0] sec [2];
  logic [CW-1:0] cnt [2];
  logic [1:0] outr, armed, done;
  logic [1:0] en, sp, trg, hasel, ev, srst, tick, mp, ms, ctlwr;
  logic [SW-1:0] sel [2];
  logic [NSRC:0] srcv;
  logic casc;
  logic [2*CW-1:0] wcnt, wpri, wsec;

  assign srcv = {sync_in, 1'b0};
  assign casc = ctl[0][3] & ctl[1][3];
  assign wcnt = {cnt[1], cnt[0]};
  assign wpri = {pri[1], pri[0]};
  assign wsec = {sec[1], sec[0]};

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      en[i]    = ctl[i][0];
      sp[i]    = ctl[i][1];
      trg[i]   = ctl[i][2];
      sel[i]   = ctl[i][SELHI:SELLO];
      hasel[i] = sel[i] != '0;
      ev[i]    = srcv[sel[i]];
      srst[i]  = en[i] & hasel[i] & ~trg[i] & ev[i];
      tick[i]  = clk_en & en[i] & ~done[i] & (~hasel[i] | ~trg[i] | armed[i]);
      ctlwr[i] = wr_en && (wr_chan == 1'(i)) && (wr_addr == 2'd0);
    end
    mp[0] = casc ? (wcnt == wpri) : (cnt[0] == pri[0]);
    ms[0] = casc ? (wcnt == wsec) : (cnt[0] == sec[0]);
    mp[1] = cnt[1] == pri[1];
    ms[1] = cnt[1] == sec[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ctl[i] <= '0;
        pri[i] <= '0;
        sec[i] <= '0;
        cnt[i] <= '0;
      end
      outr  <= '0;
      armed <= '0;
      done  <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (casc && i == 1) begin
          outr[i]  <= 1'b0;
          armed[i] <= 1'b0;
          done[i]  <= 1'b0;
          if (!en[0] || srst[0])
            cnt[i] <= '0;
          else if (tick[0] && cnt[0] == MAXV)
            cnt[i] <= cnt[i] + 1'b1;
        end else if (!en[i]) begin
          cnt[i]   <= '0;
          outr[i]  <= 1'b0;
          armed[i] <= 1'b0;
          done[i]  <= 1'b0;
        end else begin
          if (trg[i] && hasel[i] && ev[i])
            armed[i] <= 1'b1;
          if (srst[i])
            cnt[i] <= '0;
          else if (tick[i])
            cnt[i] <= cnt[i] + 1'b1;
          if (tick[i]) begin
            if (ms[i]) begin
              outr[i] <= 1'b0;
              if (sp[i]) done[i] <= 1'b1;
            end else if (mp[i]) begin
              outr[i] <= 1'b1;
            end
          end
        end
        if (ctlwr[i]) done[i] <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0:    ctl[wr_chan] <= wr_data;
          2'd1:    pri[wr_chan] <= wr_data;
          2'd2:    sec[wr_chan] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign pwm_out[0] = outr[0];
  assign pwm_out[1] = casc ? outr[0] : outr[1];

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[0] && !srst[0]) |=> cnt[0] == CW'($past(cnt[0]) + 1'b1));
  p_clash_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[0] && ms[0]) |=> !outr[0]);
  p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[0] && mp[0] && !ms[0]) |=> outr[0]);
  p_sync_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srst[0] |=> cnt[0] == '0);
  p_trig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en[0] && hasel[0] && trg[0] && !armed[0]) |=> $stable(cnt[0]));
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done[0] && !ctlwr[0]) |=> (!outr[0] && $stable(cnt[0])));
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |=> (cnt[0] == '0 && !outr[0] && !armed[0]));
  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && tick[0] && !srst[0] && cnt[0] == MAXV) |=> cnt[1] == CW'($past(cnt[1]) + 1'b1));
endmodule

// File: tb/ocpwm_pair_bench.sv
module ocpwm_pair_bench;
  localparam int CW = 9;
  localparam int SW = 5;
  localparam int NS = (1 << SW) - 1;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, clk_en = 1, wr_en = 0, wr_chan = 0;
  logic [NS-1:0] sync_in = '0;
  logic [1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0] pwm_out;

  int checks = 0, fails = 0, cyc = 0;
  bit gap = 0, finished = 0;
  string phase = "R7";

  int m_ctl[2], m_pri[2], m_sec[2], m_cnt[2], m_out[2], m_arm[2], m_done[2];

  ocpwm_pair #(.CW(CW), .SW(SW)) u_ocpwm_pair (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sync_in(sync_in),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  task automatic model_step();
    int nc[2], no[2], na[2], nd[2];
    bit casc, en, sp, trg, ev, srst, tick, hit_s, hit_p;
    int sel;
    longint full, fp, fs;
    casc = m_ctl[0][3] && m_ctl[1][3];
    full = (longint'(m_cnt[1]) << CW) | m_cnt[0];
    fp = (longint'(m_pri[1]) << CW) | m_pri[0];
    fs = (longint'(m_sec[1]) << CW) | m_sec[0];
    for (int i = 0; i < 2; i++) begin
      nc[i] = m_cnt[i]; no[i] = m_out[i]; na[i] = m_arm[i]; nd[i] = m_done[i];
    end
    for (int i = 0; i < 2; i++) begin
      en = m_ctl[i][0]; sp = m_ctl[i][1]; trg = m_ctl[i][2];
      sel = (m_ctl[i] >> 4) & NS;
      ev = (sel != 0) && sync_in[sel-1];
      srst = en && sel != 0 && !trg && ev;
      tick = clk_en && en && !m_done[i] && (sel == 0 || !trg || m_arm[i]);
      if (casc && i == 0) begin
        hit_s = full == fs; hit_p = full == fp;
      end else begin
        hit_s = m_cnt[i] == m_sec[i]; hit_p = m_cnt[i] == m_pri[i];
      end
      if (casc && i == 1) begin
        no[1] = 0; na[1] = 0; nd[1] = 0;
      end else if (!en) begin
        nc[i] = 0; no[i] = 0; na[i] = 0; nd[i] = 0;
      end else begin
        if (trg && ev) na[i] = 1;
        if (srst) nc[i] = 0;
        else if (tick) nc[i] = (m_cnt[i] + 1) & MAXV;
        if (tick) begin
          if (hit_s) begin no[i] = 0; if (sp) nd[i] = 1; end
          else if (hit_p) no[i] = 1;
        end
      end
      if (casc && i == 0) begin
        if (!en || srst) nc[1] = 0;
        else if (tick && m_cnt[0] == MAXV) nc[1] = (m_cnt[1] + 1) & MAXV;
      end
      if (wr_en && wr_chan == 1'(i) && wr_addr == 0) nd[i] = 0;
    end
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = nc[i]; m_out[i] = no[i]; m_arm[i] = na[i]; m_done[i] = nd[i];
    end
    if (wr_en) begin
      if (wr_addr == 0) m_ctl[wr_chan] = wr_data;
      if (wr_addr == 1) m_pri[wr_chan] = wr_data;
      if (wr_addr == 2) m_sec[wr_chan] = wr_data;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_ctl[i] = 0; m_pri[i] = 0; m_sec[i] = 0; m_cnt[i] = 0;
        m_out[i] = 0; m_arm[i] = 0; m_done[i] = 0;
      end
    end else model_step();
  end

  always @(negedge clk) begin
    logic [1:0] exp;
    cyc++;
    clk_en <= gap ? (cyc % 3 != 0) : 1'b1;
    exp[0] = m_out[0][0];
    exp[1] = (m_ctl[0][3] && m_ctl[1][3]) ? m_out[0][0] : m_out[1][0];
    if (rst_n && !finished) begin
      checks++;
      if (pwm_out !== exp) begin
        fails++;
        $display("FAIL %s cycle %0d: pwm_out=%b expected %b", phase, cyc, pwm_out, exp);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, int a, int d);
    @(negedge clk);
    wr_en = 1; wr_chan = ch[0]; wr_addr = a[1:0]; wr_data = d[CW-1:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(int line);
    @(negedge clk);
    sync_in[line] = 1'b1;
    @(negedge clk);
    sync_in[line] = 1'b0;
  endtask

  initial begin
    run(3);
    checks++;
    if (pwm_out !== 2'b00) begin
      fails++;
      $display("FAIL R7 reset: pwm_out=%b expected 00", pwm_out);
    end
    rst_n = 1;
    run(2);
    phase = "R1"; gap = 0;
    wr(0, 1, 10); wr(0, 2, 50); wr(0, 0, 1);
    run(1100);
    phase = "R1"; gap = 1;
    run(900);
    gap = 0;
    phase = "R9";
    wr(0, 1, 200);
    run(600);
    phase = "R2";
    wr(0, 1, 100); wr(0, 2, 100);
    run(600);
    phase = "R4";
    wr(1, 1, 30); wr(1, 2, 60); wr(1, 0, (3 << 4) | 1);
    for (int k = 0; k < 8; k++) begin
      run(90);
      pulse(2);
      run(20);
      phase = "R3";
      pulse(6);
      phase = "R4";
    end
    phase = "R5";
    wr(0, 1, 4); wr(0, 2, 40); wr(0, 0, (5 << 4) | 4 | 1);
    run(300);
    pulse(4);
    run(700);
    pulse(4);
    run(200);
    phase = "R7";
    wr(0, 0, 0);
    run(20);
    wr(0, 0, (5 << 4) | 4 | 1);
    run(100);
    phase = "R5";
    pulse(4);
    run(100);
    phase = "R6";
    wr(0, 0, 0); wr(0, 1, 5); wr(0, 2, 15); wr(0, 0, 3);
    run(700);
    wr(0, 0, 3);
    gap = 1;
    run(700);
    gap = 0;
    phase = "R8";
    wr(1, 0, 0); wr(0, 0, 0);
    wr(0, 1, 5); wr(1, 1, 1); wr(0, 2, 9); wr(1, 2, 2);
    wr(0, 0, 8 | 1);
    run(600);
    wr(1, 0, 8);
    run(1500);
    wr(0, 0, (2 << 4) | 8 | 1);
    run(600);
    pulse(1);
    run(1200);
    wr(1, 0, 0);
    run(600);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule